// File: doc/BRIEF.md
# Contact Smart Card Power Sequencer

This block controls the supply, I/O mode, clock and reset lines of a contact smart card while the card is powered up and powered down. Its clock is a 1.5 MHz internal timebase, and every interval is a whole number of cycles of that clock. A host lowers an active-low power command to start a session. The block then turns on the card supply and waits about half a millisecond before putting the I/O line into reception. It starts the card clock once the host's reset input is low. After a short hold, the card reset follows the host reset input.

Power-down can be started in two ways. The host can raise the power command, or one of four fault flags can go high: over-current, logic-supply fault, card-supply fault or card removal. The block then takes the card lines down one at a time, in a fixed order: reset first, then clock, then I/O, then supply. Each step has its own minimum gap. A fault also sets a status output, and this status stays set until the host raises the power command again.

Top module: `sc_pwr_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, every output is low. After `rst` falls, the block stays idle until it samples `pwr_cmd_n` low.
- R2: When the idle block samples `pwr_cmd_n` low with no fault present, `vcc_en` goes high at that edge. `io_rx` goes high exactly ACT_TICKS edges later.
- R3: While `io_rx` is high and the clock is not yet running, `clk_en` goes high at the first edge that samples `host_rst` low. `card_rst` stays low for RST_DLY further edges. From then on, `card_rst` shows the value of `host_rst` sampled at the previous edge.
- R4: During a session, deactivation starts at any edge that samples `pwr_cmd_n` high or any of `flt_ovc`, `flt_vdd`, `flt_vcc`, `card_removed` high.
- R5: Let the deactivation start at edge d. `card_rst` is held until edge d+RST_GAP and is low from then on. `clk_en` falls CLK_GAP edges after that, `io_rx` falls IO_GAP edges later still, and `vcc_en` falls VCC_GAP edges after `io_rx`.
- R6: A trigger that arrives before the clock is running aborts activation and runs the same deactivation timing. Any line that was not yet on stays off.
- R7: A low `pwr_cmd_n` that arrives during deactivation has no effect on the sequence. If it is still low, a new activation starts at the first edge after `vcc_en` falls.
- R8: `fault` goes high at the edge that samples a fault flag during a session, or during an activation attempt. It stays high while `pwr_cmd_n` is low and clears at the first edge that samples `pwr_cmd_n` high.
- R9: No activation starts while `fault` is high or while any fault flag is high.
- R10: At all times, `card_rst` implies `clk_en`, `clk_en` implies `io_rx`, and `io_rx` implies `vcc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.5 MHz timebase; one cycle is one tick |
| rst | input | 1 | Synchronous active-high reset |
| pwr_cmd_n | input | 1 | Power command from the host, active low |
| host_rst | input | 1 | Reset value the host wants on the card |
| flt_ovc | input | 1 | Card supply over-current flag |
| flt_vdd | input | 1 | Logic supply fault flag |
| flt_vcc | input | 1 | Card supply fault flag |
| card_removed | input | 1 | Card extraction flag |
| vcc_en | output | 1 | Card supply enable |
| io_rx | output | 1 | Card I/O in reception mode (low: I/O held low) |
| clk_en | output | 1 | Card clock gate (low: clock held low) |
| card_rst | output | 1 | Card reset line |
| fault | output | 1 | Fault status, held until the power command is raised |

## Verification
The bench builds the block with ACT_TICKS=20, CLK_GAP=5 and RST_DLY=2, and keeps RST_GAP, IO_GAP and VCC_GAP at one tick. This shortens a full session to a few dozen cycles. A sweep can then place the trigger at every edge from the first activation tick to well after the clock is running, once for each of the five trigger kinds. This covers every abort point of activation and every fault source, each against timing computed arithmetically in the bench. Directed runs cover a delayed host reset, a command re-issued during power-down, and a fault present while idle.

// File: rtl/sc_pwr_pkg.sv
package sc_pwr_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_PWR,     // supply on, waiting for I/O release
      S_RXW,     // I/O in reception, waiting for host reset low
      S_CLKH,    // clock running, card reset held low
      S_ACT,     // session: card reset follows host
      S_DRST,    // deactivation: reset held, gap before drop
      S_DCLK,    // reset low, gap before clock stop
      S_DIO,     // clock low, gap before I/O drop
      S_DVCC     // I/O low, gap before supply off
   } seq_state_t;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sc_gap_timer.sv
module sc_gap_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sc_fault_latch.sv
module sc_fault_latch (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic cmd_n,
   output logic flt_q
);
   always_ff @(posedge clk) begin
      if (rst)
         flt_q <= 1'b0;
      else if (cmd_n)
         flt_q <= 1'b0;
      else if (set)
         flt_q <= 1'b1;
   end
endmodule

// File: rtl/sc_seq_core.sv
module sc_seq_core
   import sc_pwr_pkg::*;
#(
   parameter int unsigned ACT_TICKS = 765,
   parameter int unsigned RST_DLY   = 1,
   parameter int unsigned RST_GAP   = 1,
   parameter int unsigned CLK_GAP   = 12,
   parameter int unsigned IO_GAP    = 1,
   parameter int unsigned VCC_GAP   = 1,
   parameter int unsigned CW        = 10
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cmd_n,
   input  logic          host_rst,
   input  logic          any_flt,
   input  logic          flt_lat,
   input  logic          gap_done,
   output logic          gap_load,
   output logic [CW-1:0] gap_val,
   output logic          flt_set,
   output logic          vcc_q,
   output logic          io_q,
   output logic          clk_q,
   output logic          rst_q
);
   seq_state_t st_q, st_d;
   logic       live, trig;

   assign live = (st_q == S_PWR) || (st_q == S_RXW) || (st_q == S_CLKH) || (st_q == S_ACT);
   assign trig = cmd_n || any_flt;
   assign flt_set = any_flt && (live || ((st_q == S_IDLE) && !cmd_n));

   always_comb begin
      st_d = st_q;
      if (live && trig) begin
         st_d = S_DRST;
      end else begin
         unique case (st_q)
            S_IDLE: if (!cmd_n && !any_flt && !flt_lat) st_d = S_PWR;
            S_PWR:  if (gap_done) st_d = S_RXW;
            S_RXW:  if (!host_rst) st_d = S_CLKH;
            S_CLKH: if (gap_done) st_d = S_ACT;
            S_ACT:  st_d = S_ACT;
            S_DRST: if (gap_done) st_d = S_DCLK;
            S_DCLK: if (gap_done) st_d = S_DIO;
            S_DIO:  if (gap_done) st_d = S_DVCC;
            S_DVCC: if (gap_done) st_d = S_IDLE;
            default: st_d = S_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (st_d)
         S_PWR:   gap_val = CW'(ACT_TICKS - 1);
         S_CLKH:  gap_val = CW'(RST_DLY - 1);
         S_DRST:  gap_val = CW'(RST_GAP - 1);
         S_DCLK:  gap_val = CW'(CLK_GAP - 1);
         S_DIO:   gap_val = CW'(IO_GAP - 1);
         S_DVCC:  gap_val = CW'(VCC_GAP - 1);
         default: gap_val = '0;
      endcase
   end

   assign gap_load = (st_d != st_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= S_IDLE;
         vcc_q <= 1'b0;
         io_q  <= 1'b0;
         clk_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d == S_PWR)  vcc_q <= 1'b1;
         if (st_d == S_IDLE) vcc_q <= 1'b0;
         if (st_d == S_RXW)  io_q  <= 1'b1;
         if (st_d == S_DVCC) io_q  <= 1'b0;
         if (st_d == S_CLKH) clk_q <= 1'b1;
         if (st_d == S_DIO)  clk_q <= 1'b0;
         if (st_d == S_ACT)       rst_q <= host_rst;
         else if (st_d != S_DRST) rst_q <= 1'b0;
      end
   end
endmodule

// File: rtl/sc_pwr_seq.sv
module sc_pwr_seq
   import sc_pwr_pkg::*;
#(
   parameter int unsigned ACT_TICKS = 765,
   parameter int unsigned RST_DLY   = 1,
   parameter int unsigned RST_GAP   = 1,
   parameter int unsigned CLK_GAP   = 12,
   parameter int unsigned IO_GAP    = 1,
   parameter int unsigned VCC_GAP   = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic pwr_cmd_n,
   input  logic host_rst,
   input  logic flt_ovc,
   input  logic flt_vdd,
   input  logic flt_vcc,
   input  logic card_removed,
   output logic vcc_en,
   output logic io_rx,
   output logic clk_en,
   output logic card_rst,
   output logic fault
);
   localparam int unsigned MAX_GAP = max_of(max_of(ACT_TICKS, RST_DLY),
                                     max_of(max_of(RST_GAP, CLK_GAP), max_of(IO_GAP, VCC_GAP)));
   localparam int unsigned CW = $clog2(MAX_GAP + 1);

   generate
      if (ACT_TICKS < 1 || RST_DLY < 1 || RST_GAP < 1)
         $error("sc_pwr_seq: activation and reset intervals must be at least one tick");
      if (CLK_GAP < 1 || IO_GAP < 1 || VCC_GAP < 1)
         $error("sc_pwr_seq: deactivation gaps must be at least one tick");
   endgenerate

   logic          any_flt, flt_set, gap_load, gap_done;
   logic [CW-1:0] gap_val;

   assign any_flt = flt_ovc | flt_vdd | flt_vcc | card_removed;

   sc_gap_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .done(gap_done)
   );

   sc_fault_latch u_flt (
      .clk(clk), .rst(rst), .set(flt_set), .cmd_n(pwr_cmd_n), .flt_q(fault)
   );

   sc_seq_core #(
      .ACT_TICKS(ACT_TICKS), .RST_DLY(RST_DLY), .RST_GAP(RST_GAP),
      .CLK_GAP(CLK_GAP), .IO_GAP(IO_GAP), .VCC_GAP(VCC_GAP), .CW(CW)
   ) u_core (
      .clk(clk), .rst(rst), .cmd_n(pwr_cmd_n), .host_rst(host_rst),
      .any_flt(any_flt), .flt_lat(fault), .gap_done(gap_done),
      .gap_load(gap_load), .gap_val(gap_val), .flt_set(flt_set),
      .vcc_q(vcc_en), .io_q(io_rx), .clk_q(clk_en), .rst_q(card_rst)
   );
endmodule

// File: rtl/sc_pwr_seq_chk.sv
module sc_pwr_seq_chk (
   input logic clk,
   input logic rst,
   input logic pwr_cmd_n,
   input logic flt_ovc,
   input logic flt_vdd,
   input logic flt_vcc,
   input logic card_removed,
   input logic vcc_en,
   input logic io_rx,
   input logic clk_en,
   input logic card_rst,
   input logic fault
);
   p_rst_needs_clk_r10: assert property (@(posedge clk) disable iff (rst) card_rst |-> clk_en);
   p_clk_needs_io_r10:  assert property (@(posedge clk) disable iff (rst) clk_en |-> io_rx);
   p_io_needs_vcc_r10:  assert property (@(posedge clk) disable iff (rst) io_rx |-> vcc_en);

   p_rst_before_clk_r5: assert property (@(posedge clk) disable iff (rst)
      ($fell(clk_en) && !$past(rst)) |-> !$past(card_rst));
   p_clk_before_io_r5:  assert property (@(posedge clk) disable iff (rst)
      ($fell(io_rx) && !$past(rst)) |-> !$past(clk_en));
   p_io_before_vcc_r5:  assert property (@(posedge clk) disable iff (rst)
      ($fell(vcc_en) && !$past(rst)) |-> !$past(io_rx));

   p_start_on_cmd_r2:   assert property (@(posedge clk) disable iff (rst)
      $rose(vcc_en) |-> !$past(pwr_cmd_n));
   p_no_start_flt_r9:   assert property (@(posedge clk) disable iff (rst)
      $rose(vcc_en) |-> !$past(fault) && !$past(flt_ovc | flt_vdd | flt_vcc | card_removed));
   p_fault_hold_r8:     assert property (@(posedge clk) disable iff (rst)
      ($past(fault) && !$past(pwr_cmd_n) && !$past(rst)) |-> fault);
endmodule

bind sc_pwr_seq sc_pwr_seq_chk u_chk (
   .clk(clk), .rst(rst), .pwr_cmd_n(pwr_cmd_n), .flt_ovc(flt_ovc), .flt_vdd(flt_vdd),
   .flt_vcc(flt_vcc), .card_removed(card_removed), .vcc_en(vcc_en), .io_rx(io_rx),
   .clk_en(clk_en), .card_rst(card_rst), .fault(fault)
);

// File: tb/sc_pwr_seq_tb.sv
module sc_pwr_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int A  = 20;
   localparam int RD = 2;
   localparam int RG = 1;
   localparam int CG = 5;
   localparam int IG = 1;
   localparam int VG = 1;

   logic clk = 1'b0, rst = 1'b1, pwr_cmd_n = 1'b1, host_rst = 1'b0;
   logic flt_ovc = 1'b0, flt_vdd = 1'b0, flt_vcc = 1'b0, card_removed = 1'b0;
   logic vcc_en, io_rx, clk_en, card_rst, fault;
   int   n_chk = 0, n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_pwr_seq #(.ACT_TICKS(A), .RST_DLY(RD), .RST_GAP(RG), .CLK_GAP(CG),
                .IO_GAP(IG), .VCC_GAP(VG)) u_dut (
      .clk(clk), .rst(rst), .pwr_cmd_n(pwr_cmd_n), .host_rst(host_rst),
      .flt_ovc(flt_ovc), .flt_vdd(flt_vdd), .flt_vcc(flt_vcc),
      .card_removed(card_removed), .vcc_en(vcc_en), .io_rx(io_rx),
      .clk_en(clk_en), .card_rst(card_rst), .fault(fault));

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic set_flags(input logic [3:0] f);
      {card_removed, flt_vcc, flt_vdd, flt_ovc} = f;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; pwr_cmd_n = 1'b1; host_rst = 1'b0; set_flags(4'b0);
      @(posedge clk); @(posedge clk); #1;
      chk("R1", "vcc_en in reset", vcc_en, 1'b0);
      chk("R1", "io_rx in reset", io_rx, 1'b0);
      chk("R1", "clk_en in reset", clk_en, 1'b0);
      chk("R1", "card_rst in reset", card_rst, 1'b0);
      chk("R1", "fault in reset", fault, 1'b0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // kind 0: command raised at edge d; kind 1..4: fault flag (kind-1) raised at edge d
   task automatic sweep_run(input int kind, input int d);
      int    c, i, v;
      string tag;
      c = d + RG + CG; i = c + IG; v = i + VG;
      for (int j = 0; j <= v + 2; j++) begin
         @(negedge clk);
         pwr_cmd_n = (kind == 0 && j >= d);
         set_flags((kind > 0 && j >= d) ? (4'b1 << (kind - 1)) : 4'b0);
         @(posedge clk); #1;
         tag = (j < d) ? "R2 R3" : ((d <= A + 1 + RD) ? "R4 R6" : "R4 R5");
         chk(tag, "vcc_en", vcc_en, (j < v));
         chk(tag, "io_rx", io_rx, (d > A) && (j >= A) && (j < i));
         chk(tag, "clk_en", clk_en, (d > A + 1) && (j >= A + 1) && (j < c));
         chk(tag, "card_rst", card_rst, 1'b0);
         chk("R8", "fault", fault, (kind > 0) && (j >= d));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      // sweep: every trigger kind at every edge through activation and into the session
      for (int kind = 0; kind < 5; kind++)
         for (int d = 1; d <= A + RD + 4; d++) begin
            do_reset();
            sweep_run(kind, d);
         end

      // R3: host reset high at activation delays the clock; card reset then follows
      do_reset();
      begin
         int h, t;
         h = A + 5;
         t = h + RD + 4;
         for (int j = 0; j <= t + 1; j++) begin
            @(negedge clk);
            pwr_cmd_n = (j >= t);
            host_rst  = (j < h) || (j >= h + RD + 2);
            @(posedge clk); #1;
            if (j == h - 1) chk("R3", "clk_en while host reset high", clk_en, 1'b0);
            if (j == h - 1) chk("R3", "io_rx in reception", io_rx, 1'b1);
            if (j == h)     chk("R3", "clk_en after host reset low", clk_en, 1'b1);
            if (j == h + RD - 1) chk("R3", "card_rst during hold", card_rst, 1'b0);
            if (j == h + RD + 1) chk("R3", "card_rst follows low", card_rst, 1'b0);
            if (j == h + RD + 2) chk("R3", "card_rst follows high", card_rst, 1'b1);
            if (j == t)     chk("R5", "card_rst held one gap", card_rst, 1'b1);
            if (j == t + 1) chk("R5", "card_rst low after gap", card_rst, 1'b0);
         end
      end

      // R7: command lowered again during deactivation
      do_reset();
      begin
         int d, v;
         d = A + RD + 4;
         v = d + RG + CG + IG + VG;
         for (int j = 0; j <= v + 1; j++) begin
            @(negedge clk);
            pwr_cmd_n = (j >= d) && (j < d + RG + 2);
            @(posedge clk); #1;
            if (j == d + RG + CG) chk("R7", "clk_en stopped on time", clk_en, 1'b0);
            if (j == v - 1) chk("R7", "vcc_en still on", vcc_en, 1'b1);
            if (j == v)     chk("R7", "vcc_en off at end", vcc_en, 1'b0);
            if (j == v + 1) chk("R7", "vcc_en restarts", vcc_en, 1'b1);
            if (j == v + 1) chk("R7", "io_rx off on restart", io_rx, 1'b0);
         end
      end

      // R9/R8: fault present while idle with command low, then flag drops
      do_reset();
      @(negedge clk); pwr_cmd_n = 1'b0; set_flags(4'b1000);
      @(posedge clk); #1;
      chk("R9", "vcc_en with fault flag", vcc_en, 1'b0);
      chk("R8", "fault set while idle", fault, 1'b1);
      @(negedge clk); set_flags(4'b0);
      repeat (3) @(posedge clk); #1;
      chk("R9", "vcc_en with fault latched", vcc_en, 1'b0);
      chk("R8", "fault held with command low", fault, 1'b1);
      @(negedge clk); pwr_cmd_n = 1'b1;
      @(posedge clk); #1;
      chk("R8", "fault cleared by command high", fault, 1'b0);
      @(negedge clk); pwr_cmd_n = 1'b0;
      @(posedge clk); #1;
      chk("R2", "vcc_en after fault cleared", vcc_en, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule